// File: doc/BRIEF.md
# Operand-Snooping Issue Queue for One Execution Unit

This block holds up to four decoded operations that wait in front of a single execution unit in a speculative out-of-order core. Each operation is written in with an opcode, the reorder-buffer index that will receive its result, and two source operands. Each source comes either as a finished value or as the reorder-buffer index of the operation that will produce it. While a source is still missing, its slot watches the shared result broadcast bus. When the index on the bus matches the one the slot is waiting for, the slot takes the value.

An operation whose two sources are both present is handed to the execution unit. At most one operation is handed over per cycle, and the lowest-numbered eligible slot goes first. The slot is released in the same cycle. When the commit logic signals a misspeculation, every slot is emptied at once. The surrounding core uses `iss_ready` to decide whether an operation can enter. That signal folds in the availability of a reorder-buffer slot, which the core supplies on `rob_slot_free`.

Top module: `rs_station`

## Requirements
- R1: `iss_ready` is high exactly when at least one slot is empty and `rob_slot_free` is high. An operation is written in only in a cycle where `iss_valid`, `iss_ready` are high and `flush` is low; at any other time `iss_valid` is ignored.
- R2: A source presented with its ready bit set to 1 is stored with the value given. A source presented with the ready bit at 0 is stored as a wait on the given tag.
- R3: A waiting source of an occupied slot takes `bus_val` at the clock edge where `bus_valid` is high and `bus_tag` equals its tag. Once a source is present, later broadcasts do not change it.
- R4: If a source is written in as waiting in the same cycle that the bus carries its tag, the source is stored as present with the bus value.
- R5: `disp_valid` rises only for a slot whose two sources are both present. The handover outputs are driven from stored state, so a slot that becomes complete at an edge is offered in the cycle that follows that edge.
- R6: New operations go into the lowest-numbered empty slot. When several slots are complete, the lowest-numbered one is offered, and at most one is offered per cycle. `disp_idx` gives its slot number.
- R7: A slot that is offered is empty from the next edge. It is not offered twice, and it can be refilled from the next cycle.
- R8: `flush` empties every slot at the next edge and discards any operation presented in the same cycle. A later broadcast cannot revive a flushed slot.
- R9: After reset all slots are empty, `disp_valid` is low and `iss_ready` follows `rob_slot_free`.
- R10: A broadcast whose tag differs from a waiting source leaves that source waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rob_slot_free | input | 1 | A reorder-buffer slot is available |
| iss_valid | input | 1 | An operation is presented for entry |
| iss_op | input | 4 | Opcode of the presented operation |
| iss_dst | input | 3 | Reorder-buffer index that will receive the result |
| iss_a_rdy | input | 1 | Source A is a value (1) or a tag (0) |
| iss_a_tag | input | 3 | Producer index of source A |
| iss_a_val | input | 16 | Value of source A |
| iss_b_rdy | input | 1 | Source B is a value (1) or a tag (0) |
| iss_b_tag | input | 3 | Producer index of source B |
| iss_b_val | input | 16 | Value of source B |
| iss_ready | output | 1 | An operation can be accepted this cycle |
| bus_valid | input | 1 | A result is being broadcast |
| bus_tag | input | 3 | Reorder-buffer index of the broadcast result |
| bus_val | input | 16 | Broadcast result value |
| flush | input | 1 | Misspeculation: empty all slots |
| disp_valid | output | 1 | An operation is handed to the execution unit |
| disp_idx | output | 2 | Slot number of the handed-over operation |
| disp_op | output | 4 | Opcode handed over |
| disp_dst | output | 3 | Result index handed over |
| disp_a | output | 16 | Source A value handed over |
| disp_b | output | 16 | Source B value handed over |

## Verification
The hardest state to reach from the ports is two slots becoming complete at the same edge. The bus delivers only one result per cycle, and a slot with both sources present is handed over the cycle after it is written, so two complete slots never coexist under ordinary traffic. To build that case, the stimulus fills all four slots with operations that are still waiting, and two of them wait on the same producer tag. One broadcast of that tag then completes both slots at once, which exposes the priority order and the rule that a slot is released when it is offered. The full queue built this way also serves to show that extra entries are refused and that a flush clears slots that are still waiting.

// File: rtl/rs_pkg.sv
// Shared widths and the stored-source type for the issue queue.
package rs_pkg;
    parameter int RS_ENTRIES = 4;
    parameter int RS_TAG_W   = 3;
    parameter int RS_DATA_W  = 16;
    parameter int RS_OP_W    = 4;

    // One source operand: present flag, producer tag, value.
    typedef struct packed {
        logic                 rdy;
        logic [RS_TAG_W-1:0]  tag;
        logic [RS_DATA_W-1:0] val;
    } src_t;
endpackage

// File: rtl/rs_operand.sv
// One source slot. It stores a value or waits on a producer tag and takes the
// broadcast value when the tags match, including in the cycle it is loaded.
// Assumes: load and the bus are sampled at the same edge; the caller gates load.
module rs_operand
    import rs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  src_t                 load_src,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_val,
    output src_t                 cur
);
    logic hit_new;
    logic hit_cur;

    // Match tests for the incoming source and the stored one.
    always_comb begin
        hit_new = bus_valid && !load_src.rdy && (bus_tag == load_src.tag);
        hit_cur = bus_valid && !cur.rdy && (bus_tag == cur.tag);
    end

    // Load at entry (with same-cycle bypass), otherwise snoop the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur.tag <= load_src.tag;
            cur.rdy <= load_src.rdy || hit_new;
            cur.val <= hit_new ? bus_val : load_src.val;
        end else if (hit_cur) begin
            cur.rdy <= 1'b1;
            cur.val <= bus_val;
        end
    end

    AST_SNOOP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && hit_cur) |=> (cur.rdy && cur.val == $past(bus_val))); // R3
    AST_READY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cur.rdy) |=> $stable(cur)); // R3
    AST_ENTRY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && hit_new) |=> (cur.rdy && cur.val == $past(bus_val))); // R4
endmodule

// File: rtl/rs_entry.sv
// One queue slot: occupancy, opcode, result index and two snooping sources.
// Assumes: alloc is only raised for an empty slot; flush overrides everything.
module rs_entry
    import rs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 alloc,
    input  logic                 clr,
    input  logic [RS_OP_W-1:0]   in_op,
    input  logic [RS_TAG_W-1:0]  in_dst,
    input  src_t                 in_a,
    input  src_t                 in_b,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_val,
    output logic                 occ,
    output logic                 done,
    output logic [RS_OP_W-1:0]   op,
    output logic [RS_TAG_W-1:0]  dst,
    output logic [RS_DATA_W-1:0] a_val,
    output logic [RS_DATA_W-1:0] b_val
);
    src_t src_a;
    src_t src_b;

    // Occupancy: flush wins, then fill, then release on handover.
    always_ff @(posedge clk) begin
        if (!rst_n)      occ <= 1'b0;
        else if (flush)  occ <= 1'b0;
        else if (alloc)  occ <= 1'b1;
        else if (clr)    occ <= 1'b0;
    end

    // Opcode and result index are captured at fill time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op  <= '0;
            dst <= '0;
        end else if (alloc) begin
            op  <= in_op;
            dst <= in_dst;
        end
    end

    rs_operand u_src_a (
        .clk(clk), .rst_n(rst_n), .load(alloc), .load_src(in_a),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val), .cur(src_a)
    );
    rs_operand u_src_b (
        .clk(clk), .rst_n(rst_n), .load(alloc), .load_src(in_b),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val), .cur(src_b)
    );

    // Slot is complete when occupied and both sources are present.
    always_comb begin
        done  = occ && src_a.rdy && src_b.rdy;
        a_val = src_a.val;
        b_val = src_b.val;
    end

    AST_SLOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !alloc) |=> !occ); // R7
    AST_SLOT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !occ); // R8
endmodule

// File: rtl/rs_pick_low.sv
// Fixed-priority picker: grants the lowest-numbered set request bit.
// Assumes: N is at least 1.
module rs_pick_low #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
// Issue queue for one execution unit. It fills the lowest empty slot, lets
// slots snoop the result bus, hands the lowest complete slot to the unit and
// empties everything on flush.
// Assumes: the execution unit accepts one operation per cycle without stalling.
module rs_station
    import rs_pkg::*;
#(
    parameter int N_ENT = RS_ENTRIES,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rob_slot_free,
    input  logic                 iss_valid,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic [RS_TAG_W-1:0]  iss_dst,
    input  logic                 iss_a_rdy,
    input  logic [RS_TAG_W-1:0]  iss_a_tag,
    input  logic [RS_DATA_W-1:0] iss_a_val,
    input  logic                 iss_b_rdy,
    input  logic [RS_TAG_W-1:0]  iss_b_tag,
    input  logic [RS_DATA_W-1:0] iss_b_val,
    output logic                 iss_ready,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_val,
    input  logic                 flush,
    output logic                 disp_valid,
    output logic [IDX_W-1:0]     disp_idx,
    output logic [RS_OP_W-1:0]   disp_op,
    output logic [RS_TAG_W-1:0]  disp_dst,
    output logic [RS_DATA_W-1:0] disp_a,
    output logic [RS_DATA_W-1:0] disp_b
);
    logic [N_ENT-1:0]     occ;
    logic [N_ENT-1:0]     done;
    logic [N_ENT-1:0]     free_gnt;
    logic [N_ENT-1:0]     disp_gnt;
    logic [N_ENT-1:0]     lower_mask;
    logic                 any_free;
    logic [IDX_W-1:0]     free_idx;
    logic                 accept;
    src_t                 new_a;
    src_t                 new_b;
    logic [RS_OP_W-1:0]   e_op  [N_ENT];
    logic [RS_TAG_W-1:0]  e_dst [N_ENT];
    logic [RS_DATA_W-1:0] e_a   [N_ENT];
    logic [RS_DATA_W-1:0] e_b   [N_ENT];

    // Entry gating and packing of the incoming sources.
    always_comb begin
        iss_ready = any_free && rob_slot_free;
        accept    = iss_valid && iss_ready && !flush;
        new_a     = '{rdy: iss_a_rdy, tag: iss_a_tag, val: iss_a_val};
        new_b     = '{rdy: iss_b_rdy, tag: iss_b_tag, val: iss_b_val};
    end

    rs_pick_low #(.N(N_ENT), .IDX_W(IDX_W)) u_free_pick (
        .req(~occ), .gnt(free_gnt), .any(any_free), .idx(free_idx)
    );
    rs_pick_low #(.N(N_ENT), .IDX_W(IDX_W)) u_disp_pick (
        .req(done), .gnt(disp_gnt), .any(disp_valid), .idx(disp_idx)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        rs_entry u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .alloc(accept && free_gnt[g]), .clr(disp_gnt[g]),
            .in_op(iss_op), .in_dst(iss_dst), .in_a(new_a), .in_b(new_b),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
            .occ(occ[g]), .done(done[g]), .op(e_op[g]), .dst(e_dst[g]),
            .a_val(e_a[g]), .b_val(e_b[g])
        );
    end

    // Handover mux driven by the chosen slot number.
    always_comb begin
        disp_op  = e_op[disp_idx];
        disp_dst = e_dst[disp_idx];
        disp_a   = e_a[disp_idx];
        disp_b   = e_b[disp_idx];
    end

    // Slots numbered below the handed-over one, for the priority check.
    always_comb begin
        lower_mask = '0;
        for (int i = 0; i < N_ENT; i++) lower_mask[i] = (IDX_W'(i) < disp_idx);
    end

    AST_ONE_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_gnt)); // R6
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ((done & lower_mask) == '0)); // R6
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |=> ($countones(occ) <= $past($countones(occ)))); // R1
    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !disp_valid) |=> ($countones(occ) == $past($countones(occ)) + 1)); // R1
    AST_HANDOVER_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !occ[$past(disp_idx)]); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0)); // R8
endmodule

// File: tb/rs_station_bench.sv
`timescale 1ns/1ps
module rs_station_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rob_slot_free = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [2:0]  iss_dst = '0;
    logic        iss_a_rdy = 1'b0;
    logic [2:0]  iss_a_tag = '0;
    logic [15:0] iss_a_val = '0;
    logic        iss_b_rdy = 1'b0;
    logic [2:0]  iss_b_tag = '0;
    logic [15:0] iss_b_val = '0;
    logic        iss_ready;
    logic        bus_valid = 1'b0;
    logic [2:0]  bus_tag = '0;
    logic [15:0] bus_val = '0;
    logic        flush = 1'b0;
    logic        disp_valid;
    logic [1:0]  disp_idx;
    logic [3:0]  disp_op;
    logic [2:0]  disp_dst;
    logic [15:0] disp_a;
    logic [15:0] disp_b;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rs_station u_rs_station (
        .clk(clk), .rst_n(rst_n), .rob_slot_free(rob_slot_free),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_ready(iss_ready), .bus_valid(bus_valid), .bus_tag(bus_tag),
        .bus_val(bus_val), .flush(flush), .disp_valid(disp_valid),
        .disp_idx(disp_idx), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_a(disp_a), .disp_b(disp_b)
    );

    // One single-operation case: entry, same-cycle bus, expected handover.
    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  dst;
        logic        ar;
        logic [2:0]  at;
        logic [15:0] av;
        logic        br;
        logic [2:0]  bt;
        logic [15:0] bv;
        logic        bus_on;
        logic [2:0]  btag;
        logic [15:0] bdat;
        logic        exp_go;
        logic [15:0] exp_a;
        logic [15:0] exp_b;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'h1, 3'd1, 1'b1, 3'd0, 16'h0011, 1'b1, 3'd0, 16'h0022, 1'b0, 3'd0, 16'h0000, 1'b1, 16'h0011, 16'h0022},
        '{4'h2, 3'd2, 1'b0, 3'd2, 16'h0000, 1'b1, 3'd0, 16'h0033, 1'b1, 3'd2, 16'h0AAA, 1'b1, 16'h0AAA, 16'h0033},
        '{4'h3, 3'd3, 1'b1, 3'd0, 16'h0044, 1'b0, 3'd5, 16'h0000, 1'b1, 3'd5, 16'h0BBB, 1'b1, 16'h0044, 16'h0BBB},
        '{4'h4, 3'd4, 1'b0, 3'd1, 16'h0000, 1'b0, 3'd1, 16'h0000, 1'b1, 3'd1, 16'h0CCC, 1'b1, 16'h0CCC, 16'h0CCC},
        '{4'h5, 3'd5, 1'b0, 3'd3, 16'h0000, 1'b1, 3'd0, 16'h0055, 1'b1, 3'd4, 16'h0DDD, 1'b0, 16'h0000, 16'h0000},
        '{4'h6, 3'd6, 1'b1, 3'd0, 16'h0066, 1'b0, 3'd6, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h0000, 16'h0000},
        '{4'h7, 3'd7, 1'b0, 3'd7, 16'h0000, 1'b0, 3'd0, 16'h0000, 1'b1, 3'd7, 16'h0EEE, 1'b0, 16'h0000, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic [3:0] op, input logic [2:0] dst,
                       input logic ar, input logic [2:0] at, input logic [15:0] av,
                       input logic br, input logic [2:0] bt, input logic [15:0] bv);
        iss_valid = 1'b1;
        iss_op = op; iss_dst = dst;
        iss_a_rdy = ar; iss_a_tag = at; iss_a_val = av;
        iss_b_rdy = br; iss_b_tag = bt; iss_b_val = bv;
    endtask

    task automatic bcast(input logic [2:0] t, input logic [15:0] v);
        bus_valid = 1'b1; bus_tag = t; bus_val = v;
    endtask

    task automatic idle;
        iss_valid = 1'b0; bus_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(disp_valid == 1'b0, "R9 disp_valid after reset", disp_valid, 0);
        chk(iss_ready == 1'b0, "R9 iss_ready follows rob_slot_free=0", iss_ready, 0);
        rob_slot_free = 1'b1;
        #0.5;
        chk(iss_ready == 1'b1, "R9 iss_ready follows rob_slot_free=1", iss_ready, 1);

        // R1: no reorder-buffer slot, entry ignored
        rob_slot_free = 1'b0;
        put(4'h9, 3'd1, 1'b1, 3'd0, 16'h0001, 1'b1, 3'd0, 16'h0002);
        tick();
        idle();
        rob_slot_free = 1'b1;
        chk(disp_valid == 1'b0, "R1 entry without rob slot ignored", disp_valid, 0);

        // Table walk: R2, R4, R5, R10
        for (int k = 0; k < NV; k++) begin
            put(VECS[k].op, VECS[k].dst, VECS[k].ar, VECS[k].at, VECS[k].av,
                VECS[k].br, VECS[k].bt, VECS[k].bv);
            if (VECS[k].bus_on) bcast(VECS[k].btag, VECS[k].bdat);
            tick();
            idle();
            chk(disp_valid == VECS[k].exp_go, "R5 handover only when complete", disp_valid, VECS[k].exp_go);
            if (VECS[k].exp_go) begin
                chk(disp_a == VECS[k].exp_a, "R2/R4 source A value", disp_a, VECS[k].exp_a);
                chk(disp_b == VECS[k].exp_b, "R2/R4 source B value", disp_b, VECS[k].exp_b);
                chk(disp_op == VECS[k].op && disp_dst == VECS[k].dst, "R2 opcode and result index",
                    {disp_op, disp_dst}, {VECS[k].op, VECS[k].dst});
            end
            flush = 1'b1;
            tick();
            idle();
        end

        // Fill all four slots with waiting operations (R6 fill order)
        put(4'hA, 3'd0, 1'b0, 3'd6, 16'h0000, 1'b1, 3'd0, 16'h0100);
        tick();
        put(4'hB, 3'd1, 1'b0, 3'd6, 16'h0000, 1'b1, 3'd0, 16'h0101);
        tick();
        put(4'hC, 3'd2, 1'b1, 3'd0, 16'h0200, 1'b0, 3'd3, 16'h0000);
        tick();
        put(4'hD, 3'd3, 1'b0, 3'd4, 16'h0000, 1'b1, 3'd0, 16'h0103);
        tick();
        idle();
        chk(iss_ready == 1'b0, "R1 full queue drops iss_ready", iss_ready, 0);
        put(4'hE, 3'd7, 1'b1, 3'd0, 16'h0777, 1'b1, 3'd0, 16'h0888);
        tick();
        idle();
        chk(disp_valid == 1'b0, "R1 entry into full queue ignored", disp_valid, 0);

        // R10: non-matching broadcast
        bcast(3'd5, 16'h5555);
        tick();
        idle();
        chk(disp_valid == 1'b0, "R10 mismatched tag leaves sources waiting", disp_valid, 0);

        // R3/R6: one broadcast completes slots 0 and 1 together
        bcast(3'd6, 16'h1111);
        tick();
        idle();
        chk(disp_valid && disp_idx == 2'd0 && disp_dst == 3'd0, "R6 lowest slot first",
            {disp_valid, disp_idx, disp_dst}, {1'b1, 2'd0, 3'd0});
        chk(disp_a == 16'h1111 && disp_b == 16'h0100, "R3 snooped value taken",
            {disp_a, disp_b}, {16'h1111, 16'h0100});
        tick();
        chk(disp_valid && disp_idx == 2'd1 && disp_dst == 3'd1, "R7 slot 0 released, slot 1 next",
            {disp_valid, disp_idx, disp_dst}, {1'b1, 2'd1, 3'd1});
        tick();
        chk(disp_valid == 1'b0, "R7 no second handover", disp_valid, 0);
        chk(iss_ready == 1'b1, "R7 released slots refillable", iss_ready, 1);

        // R3: source B of slot 2
        bcast(3'd3, 16'h3333);
        tick();
        idle();
        chk(disp_valid && disp_dst == 3'd2 && disp_a == 16'h0200 && disp_b == 16'h3333,
            "R3 source B snooped", {disp_dst, disp_a, disp_b}, {3'd2, 16'h0200, 16'h3333});
        tick();
        chk(disp_valid == 1'b0, "R7 slot 2 released", disp_valid, 0);

        // R8: flush with a simultaneous entry; later broadcast revives nothing
        flush = 1'b1;
        put(4'hF, 3'd5, 1'b1, 3'd0, 16'h0F0F, 1'b1, 3'd0, 16'hF0F0);
        tick();
        idle();
        chk(disp_valid == 1'b0, "R8 entry during flush discarded", disp_valid, 0);
        bcast(3'd4, 16'h4444);
        tick();
        idle();
        chk(disp_valid == 1'b0, "R8 flushed slot stays empty", disp_valid, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule